// File: doc/BRIEF.md
# Extended-Range Programmable Feedback Divider

This block is the programmable integer part of the feedback divider in a fractional-N synthesizer. Its input clock stands for the oscillator after the fixed high-speed prescaling stages. It emits one single-cycle pulse on `divOut` for every R input clocks. R is a 6-bit ratio word.

The core is a cascade of five divide-by-2/3 cells. Each cell divides its input by two. It divides by three, once per output period, when its program bit is set and the modulus-control signal from the cell above it is asserted. With all five cells in use, the cascade covers R = 32..63, and R = 32 + the low five bits. Extension logic bypasses the upper cells whose position is at or above the most significant set bit of R. It holds their modulus-control path high, so a shorter cascade covers 4..31. The full 4..63 range is therefore contiguous.

The ratio word is captured only at the end of an output period and while reset is held. A new ratio therefore always takes effect at a clean period boundary.

Top module: `ext_range_mmd`

## Requirements
- R1: While `rst` is high at a rising edge, `divOut` is low after that edge. After `rst` falls, the first `divOut` pulse follows the R-th rising edge, where R is the ratio sampled at the last reset edge.
- R2: For ratio values 32..63, successive `divOut` pulses are exactly R input clocks apart.
- R3: For ratio values 4..31, reached by bypassing the upper cells, successive `divOut` pulses are exactly R input clocks apart.
- R4: A change of `ratio` in the middle of a period does not alter the length of that period.
- R5: Each period uses the value of `ratio` present at the rising edge that ended the previous period. This holds when the ratio changes on every period.
- R6: Ratio values 0..3 are treated as 4.
- R7: `divOut` is high for exactly one input clock per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled oscillator clock; every rising edge is one count |
| rst | input | 1 | Synchronous reset, active high; loads the ratio word |
| ratio | input | 6 | Division ratio R, unsigned, range 4..63 (lower values act as 4) |
| divOut | output | 1 | One-clock pulse per output period, registered |

## Verification
A corrupted cell counter or a wrongly decoded bypass mask changes the spacing of the `divOut` pulses. The error shows in the first period that uses the affected cell, so it is visible within at most 63 clocks of the fault. A ratio latched at the wrong moment gives a period whose length matches neither the old ratio nor the new one, right at the changeover. The bench therefore measures every interval between pulses against the ratio present at the edge that started that interval.

// File: rtl/ext_range_mmd_pkg.sv
package ext_range_mmd_pkg;

  localparam int CELL_COUNT = 5;
  localparam int MIN_CELLS  = 2;
  localparam int RATIO_W    = CELL_COUNT + 1;
  localparam int RATIO_MIN  = 1 << MIN_CELLS;

  // Per-cell configuration handed from control to the cell chain
  typedef struct packed {
    logic [CELL_COUNT-1:0] active;  // cell takes part in the cascade
    logic [CELL_COUNT-1:0] prog;    // cell may swallow one extra clock
  } cellCfg_t;

  function automatic logic [RATIO_W-1:0] clampRatio(input logic [RATIO_W-1:0] r);
    return (int'(r) < RATIO_MIN) ? RATIO_W'(RATIO_MIN) : r;
  endfunction

endpackage

// File: rtl/ext_range_mmd_ctrl.sv
module ext_range_mmd_ctrl
  import ext_range_mmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               periodEnd,
  output logic [RATIO_W-1:0] ratioEff,
  output cellCfg_t           cfg
);

  localparam int MSB_W = $clog2(RATIO_W);

  logic [RATIO_W-1:0] ratioQ;
  logic [MSB_W-1:0]   msbPos;

  // Ratio is only taken at a period boundary or under reset
  always_ff @(posedge clk) begin
    if (rst || periodEnd) ratioQ <= clampRatio(ratio);
  end

  assign ratioEff = ratioQ;

  // Cascade length equals the position of the leading one
  always_comb begin
    msbPos = '0;
    for (int i = 0; i < RATIO_W; i++) begin
      if (ratioQ[i]) msbPos = MSB_W'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < CELL_COUNT; i++) begin
      cfg.active[i] = (i < int'(msbPos));
      cfg.prog[i]   = cfg.active[i] & ratioQ[i];
    end
  end

endmodule

// File: rtl/ext_range_mmd_chain.sv
module ext_range_mmd_chain
  import ext_range_mmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cellCfg_t cfg,
  output logic     periodEnd,
  output logic     divOut
);

  logic [1:0]            cnt  [CELL_COUNT];
  logic [CELL_COUNT-1:0] tick;
  logic [CELL_COUNT-1:0] last;
  logic [1:0]            lenM1;
  logic                  modCtl;
  logic                  carry;

  // Modulus control flows from the top cell down; a bypassed cell
  // has length one, is always in its final interval, and passes it on.
  always_comb begin
    modCtl = 1'b1;
    lenM1  = 2'd0;
    for (int i = CELL_COUNT - 1; i >= 0; i--) begin
      lenM1   = cfg.active[i] ? (2'd1 + {1'b0, cfg.prog[i] & modCtl}) : 2'd0;
      last[i] = (cnt[i] == lenM1);
      modCtl  = modCtl & last[i];
    end
  end

  // Output events ripple upward: a cell steps when all below complete
  always_comb begin
    carry = 1'b1;
    for (int i = 0; i < CELL_COUNT; i++) begin
      tick[i] = carry;
      carry   = carry & last[i];
    end
    periodEnd = carry;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < CELL_COUNT; i++) begin
      if (rst)          cnt[i] <= 2'd0;
      else if (tick[i]) cnt[i] <= last[i] ? 2'd0 : cnt[i] + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) divOut <= 1'b0;
    else     divOut <= periodEnd;
  end

endmodule

// File: rtl/ext_range_mmd.sv
module ext_range_mmd
  import ext_range_mmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  output logic               divOut
);

  cellCfg_t           cfg;
  logic               periodEnd;
  logic [RATIO_W-1:0] ratioEff;

  ext_range_mmd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ratio     (ratio),
    .periodEnd (periodEnd),
    .ratioEff  (ratioEff),
    .cfg       (cfg)
  );

  ext_range_mmd_chain u_chain (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg),
    .periodEnd (periodEnd),
    .divOut    (divOut)
  );

endmodule

// File: rtl/ext_range_mmd_chk.sv
module ext_range_mmd_chk
  import ext_range_mmd_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [RATIO_W-1:0] ratio,
  input logic               divOut,
  input logic               periodEnd,
  input logic [RATIO_W-1:0] ratioEff
);

  logic [RATIO_W:0] sinceStart;

  always_ff @(posedge clk) begin
    if (rst || periodEnd) sinceStart <= '0;
    else                  sinceStart <= sinceStart + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !divOut);

  p_period_len_r2_r3: assert property (@(posedge clk) disable iff (rst)
    periodEnd |-> ((sinceStart + 1'b1) == {1'b0, ratioEff}));

  p_hold_ratio_r4: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(ratioEff));

  p_load_ratio_r5: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> (ratioEff == clampRatio($past(ratio))));

  p_floor_r6: assert property (@(posedge clk) disable iff (rst)
    int'(ratioEff) >= RATIO_MIN);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    divOut |=> !divOut);

endmodule

bind ext_range_mmd ext_range_mmd_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ratio     (ratio),
  .divOut    (divOut),
  .periodEnd (periodEnd),
  .ratioEff  (ratioEff)
);

// File: tb/ext_range_mmd_test.sv
`timescale 1ns/1ps
module ext_range_mmd_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] ratio = 6'd10;
  logic       divOut;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  int curExp = 10;
  int curRaw = 10;
  bit firstAfterRst = 1'b1;
  bit prevOut = 1'b0;
  bit edgeRst = 1'b1;
  logic [5:0] edgeRatio = 6'd10;
  string phase = "start";

  always #5 clk = ~clk;

  ext_range_mmd uut (
    .clk    (clk),
    .rst    (rst),
    .ratio  (ratio),
    .divOut (divOut)
  );

  function automatic int expOf(input int r);
    return (r < 4) ? 4 : r;
  endfunction

  // Inputs as seen by the design at the last rising edge
  always @(posedge clk) begin
    edgeRst   <= rst;
    edgeRatio <= ratio;
  end

  always @(negedge clk) begin
    if (edgeRst) begin
      checks++;
      if (divOut !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: divOut=%b expected 0", divOut);
      end
      cnt = 0;
      firstAfterRst = 1'b1;
      curRaw = int'(edgeRatio);
      curExp = expOf(curRaw);
      prevOut = 1'b0;
    end else begin
      cnt++;
      if (divOut === 1'b1) begin
        checks++;
        if (prevOut) begin
          errors++;
          $display("FAIL R7 pulse width: divOut high two clocks, expected 1 (phase %s)", phase);
        end
        checks++;
        if (cnt != curExp) begin
          errors++;
          $display("FAIL %s period (ratio %0d, phase %s): %0d clocks expected %0d",
                   firstAfterRst ? "R1" : (curRaw < 4) ? "R6" : (curExp < 32) ? "R3" : "R2",
                   curRaw, phase, cnt, curExp);
        end
        cnt = 0;
        firstAfterRst = 1'b0;
        curRaw = int'(edgeRatio);
        curExp = expOf(curRaw);
      end else if (cnt > 70) begin
        checks++;
        errors++;
        $display("FAIL R2 no pulse: %0d clocks expected %0d (phase %s)", cnt, curExp, phase);
        cnt = 0;
      end
      prevOut = (divOut === 1'b1);
    end
  end

  task automatic waitPulse();
    do @(negedge clk); while (divOut !== 1'b1);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    waitPulse();   // first period, R1
    waitPulse();

    // Sweep every ratio word, including the clamped ones (R2, R3, R6)
    phase = "sweep";
    for (int r = 0; r < 64; r++) begin
      ratio = 6'(r);
      waitPulse();
      waitPulse();
    end

    // R4: mid-period change must not touch the running period
    phase = "R4";
    ratio = 6'd40;
    waitPulse();
    waitPulse();
    repeat (5) @(negedge clk);
    ratio = 6'd7;
    waitPulse();
    waitPulse();
    repeat (3) @(negedge clk);
    ratio = 6'd55;
    waitPulse();
    waitPulse();

    // R5: a new word after every pulse
    phase = "R5";
    for (int k = 0; k < 150; k++) begin
      waitPulse();
      ratio = 6'($urandom_range(0, 63));
    end
    waitPulse();

    // R1: reset in the middle of a period restarts counting
    phase = "R1";
    ratio = 6'd20;
    waitPulse();
    repeat (7) @(negedge clk);
    rst = 1'b1;
    ratio = 6'd13;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    waitPulse();
    waitPulse();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

endmodule